// File: doc/BRIEF.md
# Lockable Region Status Register

This block keeps a three-bit region-lock code and serves it to a host over a four-wire SPI link (mode 0: the host changes SCK low→high to send a bit, and the block changes its output on SCK high→low). A two-byte lock instruction replaces the code. The code stays as written until the next accepted lock instruction. The block also turns the code into a write-inhibit flag for any byte address of a 512-byte array. The array's write path asks about an address on `chk_addr` and gets the answer on `chk_locked`. Locked bytes can still be read; only their writes are refused.

The same write path reports a nonvolatile write in progress on `nv_busy`. While that flag is high, a status read returns ones instead of the code. The block's internal bit pointer keeps moving with SCK during that time, so once `nv_busy` falls the host sees the real status bits from whatever position the pointer has reached.

SPI pins are passed through a parameterised synchronizer and sampled on the system clock. SCK must therefore stay in each level for several system clock cycles.

Top module: `lock_region_status`

## Requirements
- R1: After synchronous reset the lock code is 0, `spi_miso` is low and `chk_locked` is low for every address.
- R2: A frame made of opcode 0x01 and then one data byte, both sent MSB first, with exactly 16 SCK rising edges while chip select is low, sets the lock code to data bits [2:0]. The new code takes effect when chip select rises, and only if `wr_en_latch` is high at that moment.
- R3: A lock frame is discarded if `wr_en_latch` is low when chip select rises, if the number of SCK rising edges is not exactly 16, or if the opcode is not 0x01.
- R4: The lock code changes only when a lock frame is accepted. Status reads, discarded frames and `nv_busy` leave it unchanged.
- R5: `chk_locked` is high exactly when `chk_addr` lies in the region for the current code, with 16-byte pages. The regions are: 0 none; 1 the top page (0x1F0–0x1FF); 2 the top 2 pages; 3 the top 4 pages; 4 the top 8 pages; 5 the top 16 pages (0x100–0x1FF); 6 page 0 only (0x000–0x00F); 7 the lower half (0x000–0x0FF).
- R6: After opcode 0x05, each SCK falling edge from the one following the 8th rising edge onward drives the next bit of the status byte {5'b00000, code} onto `spi_miso`, MSB first. The byte repeats for as long as clocking continues.
- R7: While `nv_busy` is high during a status read, each SCK falling edge drives `spi_miso` high and still advances the bit pointer. After `nv_busy` falls, the next bit sent is the status bit at the pointer's current position.
- R8: `spi_miso` is low while chip select is high and throughout any frame that is not a status read.
- R9: Data bits [7:3] of a lock frame are ignored, and status bits [7:3] always read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_sck | input | 1 | SPI serial clock, idle low |
| spi_mosi | input | 1 | SPI data from the host |
| spi_miso | output | 1 | SPI data to the host |
| wr_en_latch | input | 1 | Write-enable latch state from the write path |
| nv_busy | input | 1 | Nonvolatile write in progress |
| chk_addr | input | 9 | Byte address to test for write inhibit |
| chk_locked | output | 1 | Write inhibit for `chk_addr` |
| lock_code | output | 3 | Current lock code |

## Verification
The hardest case to reach is the busy-to-ready change in the middle of a status byte. To show that the pointer kept moving, `nv_busy` has to fall between two particular SCK falling edges, and the bits that follow must come from the middle of the byte rather than from its MSB. The bench holds `nv_busy` high for a chosen number of output bits inside a read frame, so the change lands at a known pointer position. A per-bit reference then predicts ones followed by the remaining status bits. Frames with 15 and 17 rising edges, a frame with the enable low, and a frame with a foreign opcode probe the commit rule right at its boundaries.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;

    localparam int STAT_W   = 8;
    localparam int CODE_W   = 3;
    localparam int FRAME_W  = 2 * STAT_W;

    localparam logic [STAT_W-1:0] OP_SET_LOCK = 8'h01;
    localparam logic [STAT_W-1:0] OP_GET_STAT = 8'h05;

    typedef logic [CODE_W-1:0] lock_code_t;

    typedef enum logic [1:0] {
        FR_OPCODE,
        FR_STATUS,
        FR_LOCK,
        FR_OTHER
    } fr_state_t;

    typedef struct packed {
        logic active;
        logic cs_rise;
        logic sck_rise;
        logic sck_fall;
        logic mosi;
    } spi_evt_t;

    // Region membership of one page for a given code.
    function automatic logic region_hit(input lock_code_t code,
                                        input int unsigned page,
                                        input int unsigned npages);
        int unsigned span;
        logic        hit;
        span = 32'd1;
        hit  = 1'b0;
        case (code)
            3'd0:    hit = 1'b0;
            3'd6:    hit = (page == 0);
            3'd7:    hit = (page < npages / 2);
            default: begin
                span = 32'd1 << (code - 3'd1);
                hit  = (page >= npages - span);
            end
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/spi_edge_sync.sv
module spi_edge_sync
    import lockreg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sck,
    input  logic     mosi,
    output spi_evt_t evt
);

    logic [SYNC_STAGES-1:0] sck_sr, cs_sr, mo_sr;
    logic sck_d, cs_d;
    logic sck_s, cs_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_sr <= '0;
            cs_sr  <= '1;
            mo_sr  <= '0;
            sck_d  <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            for (int i = SYNC_STAGES - 1; i > 0; i--) begin
                sck_sr[i] <= sck_sr[i-1];
                cs_sr[i]  <= cs_sr[i-1];
                mo_sr[i]  <= mo_sr[i-1];
            end
            sck_sr[0] <= sck;
            cs_sr[0]  <= cs_n;
            mo_sr[0]  <= mosi;
            sck_d     <= sck_sr[SYNC_STAGES-1];
            cs_d      <= cs_sr[SYNC_STAGES-1];
        end
    end

    assign sck_s = sck_sr[SYNC_STAGES-1];
    assign cs_s  = cs_sr[SYNC_STAGES-1];

    always_comb begin
        evt.active   = ~cs_s;
        evt.cs_rise  = cs_s & ~cs_d;
        evt.sck_rise = sck_s & ~sck_d & ~cs_s;
        evt.sck_fall = ~sck_s & sck_d & ~cs_s;
        evt.mosi     = mo_sr[SYNC_STAGES-1];
    end

endmodule

// File: rtl/frame_decoder.sv
module frame_decoder
    import lockreg_pkg::*;
#(
    parameter int CNT_W = $clog2(FRAME_W + 1) + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       cs_rise,
    input  logic       sck_rise,
    input  logic       mosi,
    input  logic       wel,
    output logic       commit,
    output lock_code_t new_code,
    output logic       rd_open
);

    localparam int SH_W = STAT_W - 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [SH_W-1:0]   sh;
    logic [CNT_W-1:0]  cnt;
    fr_state_t         state;
    logic [STAT_W-1:0] next_byte;

    assign next_byte = {sh, mosi};

    always_ff @(posedge clk) begin
        if (rst) begin
            sh    <= '0;
            cnt   <= '0;
            state <= FR_OPCODE;
        end else if (!active) begin
            cnt   <= '0;
            state <= FR_OPCODE;
        end else if (sck_rise) begin
            sh <= next_byte[SH_W-1:0];
            if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
            if (cnt == CNT_W'(STAT_W - 1)) begin
                if (next_byte == OP_GET_STAT)      state <= FR_STATUS;
                else if (next_byte == OP_SET_LOCK) state <= FR_LOCK;
                else                               state <= FR_OTHER;
            end
        end
    end

    assign commit   = cs_rise && (state == FR_LOCK) && (cnt == CNT_W'(FRAME_W)) && wel;
    assign new_code = sh[CODE_W-1:0];
    assign rd_open  = active && (state == FR_STATUS);

    // R3: an accepted commit needs the enable and a full-length lock frame
    p_commit_gate_r3: assert property (@(posedge clk) disable iff (rst)
        commit |-> (wel && $past(cnt == CNT_W'(FRAME_W))));

    // R6: the read window opens only once the opcode is complete
    p_read_after_op_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_open) |-> (cnt == CNT_W'(STAT_W)));

endmodule

// File: rtl/status_tx.sv
module status_tx
    import lockreg_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       active,
    input  logic       sck_fall,
    input  logic       rd_open,
    input  logic       busy,
    input  lock_code_t code,
    output logic       miso
);

    localparam int PTR_W = $clog2(STAT_W);
    localparam logic [PTR_W-1:0] PTR_TOP = PTR_W'(STAT_W - 1);

    logic [STAT_W-1:0] stat_byte;
    logic [PTR_W-1:0]  ptr;

    assign stat_byte = {{(STAT_W-CODE_W){1'b0}}, code};

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr  <= PTR_TOP;
            miso <= 1'b0;
        end else if (!active) begin
            ptr  <= PTR_TOP;
            miso <= 1'b0;
        end else if (rd_open && sck_fall) begin
            miso <= busy ? 1'b1 : stat_byte[ptr];
            ptr  <= ptr - 1'b1;
        end
    end

    // R7: busy forces a high bit on the line
    p_busy_high_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_open && sck_fall && busy) |=> miso);

    // R7: the pointer walks on every output edge, busy or not
    p_ptr_walk_r7: assert property (@(posedge clk) disable iff (rst)
        (active && rd_open && sck_fall) |=> (ptr == $past(ptr) - 1'b1));

    // R8: the line is quiet while deselected
    p_quiet_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !active |=> !miso);

    // R9: pad bits of the status byte read as zero
    p_pad_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (active && rd_open && sck_fall && !busy && ptr >= PTR_W'(CODE_W)) |=> !miso);

endmodule

// File: rtl/region_decode.sv
module region_decode
    import lockreg_pkg::*;
#(
    parameter int ADDR_W = 9,
    parameter int PAGE_W = 4
) (
    input  lock_code_t        code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam int PG_IDX_W = ADDR_W - PAGE_W;
    localparam int NPAGES   = 1 << PG_IDX_W;

    logic [PG_IDX_W-1:0] page;

    assign page = addr[ADDR_W-1:PAGE_W];

    always_comb begin
        hit = region_hit(code, 32'(page), NPAGES);
    end

endmodule

// File: rtl/lock_region_status.sv
module lock_region_status
    import lockreg_pkg::*;
#(
    parameter int ADDR_W      = 9,
    parameter int PAGE_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_cs_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    input  logic              wr_en_latch,
    input  logic              nv_busy,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic              chk_locked,
    output logic [CODE_W-1:0] lock_code
);

    spi_evt_t   evt;
    logic       commit;
    logic       rd_open;
    lock_code_t new_code;
    lock_code_t code_q;

    spi_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (spi_cs_n),
        .sck  (spi_sck),
        .mosi (spi_mosi),
        .evt  (evt)
    );

    frame_decoder u_frame (
        .clk      (clk),
        .rst      (rst),
        .active   (evt.active),
        .cs_rise  (evt.cs_rise),
        .sck_rise (evt.sck_rise),
        .mosi     (evt.mosi),
        .wel      (wr_en_latch),
        .commit   (commit),
        .new_code (new_code),
        .rd_open  (rd_open)
    );

    always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (commit) code_q <= new_code;
    end

    status_tx u_tx (
        .clk      (clk),
        .rst      (rst),
        .active   (evt.active),
        .sck_fall (evt.sck_fall),
        .rd_open  (rd_open),
        .busy     (nv_busy),
        .code     (code_q),
        .miso     (spi_miso)
    );

    region_decode #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .code (code_q),
        .addr (chk_addr),
        .hit  (chk_locked)
    );

    assign lock_code = code_q;

    // R2: an accepted frame loads the decoded payload
    p_commit_load_r2: assert property (@(posedge clk) disable iff (rst)
        commit |=> (code_q == $past(new_code)));

    // R4: the code holds between accepted frames
    p_code_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !commit |=> $stable(code_q));

    // R5: code zero never inhibits a write
    p_unlocked_free_r5: assert property (@(posedge clk) disable iff (rst)
        (code_q == '0) |-> !chk_locked);

endmodule

// File: tb/tb_lock_region_status.sv
module tb_lock_region_status;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       spi_cs_n = 1'b1;
    logic       spi_sck = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       spi_miso;
    logic       wr_en_latch = 1'b0;
    logic       nv_busy = 1'b0;
    logic [8:0] chk_addr = '0;
    logic       chk_locked;
    logic [2:0] lock_code;

    int errors = 0;
    int checks = 0;
    int settle = 0;
    int cyc = 0;
    logic [2:0] model_code = 3'd0;

    always #2.5 clk = ~clk;

    lock_region_status dut (
        .clk         (clk),
        .rst         (rst),
        .spi_cs_n    (spi_cs_n),
        .spi_sck     (spi_sck),
        .spi_mosi    (spi_mosi),
        .spi_miso    (spi_miso),
        .wr_en_latch (wr_en_latch),
        .nv_busy     (nv_busy),
        .chk_addr    (chk_addr),
        .chk_locked  (chk_locked),
        .lock_code   (lock_code)
    );

    function automatic logic ref_locked(input logic [2:0] c, input int a);
        case (c)
            3'd1:    return a >= 496;
            3'd2:    return a >= 480;
            3'd3:    return a >= 448;
            3'd4:    return a >= 384;
            3'd5:    return a >= 256;
            3'd6:    return a < 16;
            3'd7:    return a < 256;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Reference model compared on every clock, just after the edge.
    always @(posedge clk) begin
        cyc++;
        #1;
        if (settle > 0) settle--;
        else if (!rst) begin
            chk(lock_code == model_code, "R4 code held", lock_code, model_code);
            chk(chk_locked == ref_locked(model_code, chk_addr), "R5 inhibit map",
                chk_locked, ref_locked(model_code, chk_addr));
            if (spi_cs_n) chk(spi_miso == 1'b0, "R8 miso idle", spi_miso, 0);
        end
    end

    always @(posedge clk) begin
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    // One SPI frame; checks miso after every SCK falling edge.
    task automatic frame(input logic [7:0] op, input logic [7:0] data, input int nbits,
                         input bit wel, input int busy_bits, input string req);
        logic [7:0] stat;
        bit is_read;
        stat    = {5'b00000, model_code};
        is_read = (op == 8'h05) && (nbits >= 8);
        @(negedge clk);
        wr_en_latch = wel;
        spi_cs_n    = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            logic exp;
            spi_mosi = (i < 8) ? op[7-i] : (i < 16) ? data[15-i] : 1'b0;
            nv_busy  = is_read && (i >= 7) && ((i - 7) < busy_bits);
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sck = 1'b0;
            repeat (HALF) @(negedge clk);
            if (is_read && i >= 7)
                exp = nv_busy ? 1'b1 : stat[7 - ((i - 7) % 8)];
            else
                exp = 1'b0;
            chk(spi_miso == exp, req, spi_miso, exp);
        end
        nv_busy = 1'b0;
        if (op == 8'h01 && nbits == 16 && wel) model_code = data[2:0];
        settle   = 12;
        spi_cs_n = 1'b1;
        repeat (14) @(negedge clk);
        wr_en_latch = 1'b0;
    endtask

    initial begin
        settle = 1000;
        repeat (5) @(negedge clk);
        rst    = 1'b0;
        settle = 0;
        @(negedge clk);
        // R1: reset state
        chk(lock_code == 3'd0, "R1 reset code", lock_code, 0);
        chk(spi_miso == 1'b0, "R1 reset miso", spi_miso, 0);
        chk(chk_locked == 1'b0, "R1 reset inhibit", chk_locked, 0);

        frame(8'h05, 8'h00, 24, 1'b0, 0, "R6 read code 0");
        frame(8'h01, 8'h03, 16, 1'b1, 0, "R8 miso in lock frame");
        chk(lock_code == 3'd3, "R2 commit code 3", lock_code, 3);
        frame(8'h05, 8'h00, 24, 1'b0, 0, "R6 read code 3 twice");

        frame(8'h01, 8'h06, 16, 1'b0, 0, "R8 miso");
        chk(lock_code == 3'd3, "R3 enable low discards", lock_code, 3);
        frame(8'h01, 8'h06, 17, 1'b1, 0, "R8 miso");
        chk(lock_code == 3'd3, "R3 17 edges discards", lock_code, 3);
        frame(8'h01, 8'h06, 15, 1'b1, 0, "R8 miso");
        chk(lock_code == 3'd3, "R3 15 edges discards", lock_code, 3);
        frame(8'h02, 8'h06, 16, 1'b1, 0, "R8 miso other opcode");
        chk(lock_code == 3'd3, "R3 foreign opcode discards", lock_code, 3);

        frame(8'h01, 8'hFD, 16, 1'b1, 0, "R8 miso");
        chk(lock_code == 3'd5, "R9 high data bits ignored", lock_code, 5);
        frame(8'h05, 8'h00, 16, 1'b0, 0, "R9 pad bits read zero");

        frame(8'h05, 8'h00, 16, 1'b0, 3, "R7 busy then pointer position");
        frame(8'h05, 8'h00, 24, 1'b0, 10, "R7 busy across byte boundary");
        chk(lock_code == 3'd5, "R4 reads keep code", lock_code, 5);

        for (int c = 0; c < 8; c++) begin
            frame(8'h01, 8'(c), 16, 1'b1, 0, "R8 miso");
            chk(lock_code == 3'(c), "R2 commit sweep", lock_code, c);
            for (int a = 0; a < 512; a++) begin
                @(negedge clk);
                chk_addr = 9'(a);
            end
            @(negedge clk);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule